// File: doc/BRIEF.md
# Shared Forward/Inverse AES Byte Substitution

This block is a purely combinational byte substitution unit for AES. One mode input selects the direction. With the mode low it computes the forward S-box used by SubBytes. With the mode high it computes the inverse S-box used by InvSubBytes. Both directions pass through the same multiplicative inverter. That inverter works in a composite field GF((2^4)^2) rather than directly in GF(2^8).

On the way in, a byte is changed to the composite basis. In decryption the affine step is undone first. On the way out, the result is changed back to the standard basis. In encryption the forward affine step is then applied.

Inside the inverter, a scalar-square term multiplies the squared high nibble by a fixed subfield constant. The basis-change matrices and that constant are derived at elaboration from the field polynomials. No substitution table is stored anywhere. The unit has no clock, so an instantiating datapath adds registers wherever its timing needs them.

Top module: `aes_sbox_shared`

## Requirements
- R1: With `mode_dec` = 0, `dout` equals the FIPS-197 forward S-box of `din` for all 256 inputs. The forward S-box is the GF(2^8) inverse (using 0 for 0, polynomial 0x11B) followed by b' = A·b XOR 0x63.
- R2: With `mode_dec` = 1, `dout` equals the inverse S-box of `din` for all 256 inputs. The inverse S-box undoes the affine step, b = A^-1·(b' XOR 0x63), and then takes the GF(2^8) inverse.
- R3: The zero corner holds: forward 0x00 gives 0x63, and inverse 0x63 gives 0x00.
- R4: For every byte x, passing x forward and then feeding the result back with `mode_dec` = 1 returns x.
- R5: For every byte x, passing x inverse and then feeding the result back with `mode_dec` = 0 returns x.
- R6: Neither direction has a fixed point: `dout` never equals `din` in either mode.
- R7: Changing only `mode_dec` with `din` held changes `dout` to the other direction's value in the same evaluation. For example, din 0x53 gives 0xED forward and 0x50 inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_dec | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte |

## Verification
The basis matrices, the subfield constant and the inverter are all shared. A wrong coefficient or an incorrectly routed nibble anywhere in them therefore corrupts many bytes in both directions. The corruption appears at `dout` in the same evaluation as the input that exercises it.

The bench sweeps all 256 bytes in each mode against a model computed by exponentiation in GF(2^8). It also runs the round trips in both orders, so an error confined to one direction's affine fold still breaks R4 or R5. The zero byte receives its own checks, because a faulty inverter can send it to a nonzero value while every other byte stays correct.

// File: rtl/aes_sbox_shared.sv
module aes_sbox_shared (
  input  logic       mode_dec,
  input  logic [7:0] din,
  output logic [7:0] dout
);

  function automatic logic [7:0] g8_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [3:0] g4_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc, x;
    acc = '0;
    x = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc ^= x;
      x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic logic [3:0] g4_sq(input logic [3:0] a);
    return g4_mul(a, a);
  endfunction

  function automatic logic [3:0] g4_inv(input logic [3:0] a);
    logic [3:0] p2, p4, p8;
    p2 = g4_sq(a);
    p4 = g4_sq(p2);
    p8 = g4_sq(p4);
    return g4_mul(g4_mul(p2, p4), p8);
  endfunction

  function automatic logic [3:0] find_lambda();
    for (int v = 1; v < 16; v++) begin
      logic ok;
      ok = 1'b1;
      for (int t = 0; t < 16; t++)
        if ((g4_sq(4'(t)) ^ 4'(t)) == 4'(v)) ok = 1'b0;
      if (ok) return 4'(v);
    end
    return 4'h0;
  endfunction

  function automatic logic [7:0] find_omega();
    for (int c = 2; c < 256; c++) begin
      logic [7:0] c2;
      c2 = g8_mul(8'(c), 8'(c));
      if ((g8_mul(c2, c2) ^ 8'(c) ^ 8'h01) == 8'h00) return 8'(c);
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] embed16(input logic [3:0] v, input logic [7:0] om);
    logic [7:0] acc, p;
    acc = '0;
    p = 8'h01;
    for (int i = 0; i < 4; i++) begin
      if (v[i]) acc ^= p;
      p = g8_mul(p, om);
    end
    return acc;
  endfunction

  function automatic logic [7:0] find_root(input logic [7:0] lam_img);
    for (int c = 2; c < 256; c++)
      if ((g8_mul(8'(c), 8'(c)) ^ 8'(c) ^ lam_img) == 8'h00) return 8'(c);
    return 8'h00;
  endfunction

  function automatic logic [7:0] lin_map(input logic [63:0] cols, input logic [7:0] v);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++)
      if (v[i]) acc ^= cols[8*i +: 8];
    return acc;
  endfunction

  function automatic logic [63:0] build_to_std(input logic [3:0] lam);
    logic [7:0] om, yr;
    logic [63:0] cols;
    om = find_omega();
    yr = find_root(embed16(lam, om));
    for (int i = 0; i < 4; i++) begin
      cols[8*i +: 8]     = embed16(4'(1 << i), om);
      cols[8*(i+4) +: 8] = g8_mul(yr, embed16(4'(1 << i), om));
    end
    return cols;
  endfunction

  function automatic logic [63:0] build_to_cmp(input logic [63:0] fwd);
    logic [63:0] cols;
    cols = '0;
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < 256; c++)
        if (lin_map(fwd, 8'(c)) == 8'(1 << i)) cols[8*i +: 8] = 8'(c);
    return cols;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  function automatic logic [7:0] affine_fwd(input logic [7:0] b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] affine_inv(input logic [7:0] b);
    return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction

  function automatic logic [3:0] scalar_sq(input logic [3:0] lam, input logic [3:0] h);
    return g4_mul(lam, g4_sq(h));
  endfunction

  localparam logic [3:0]  LAMBDA = find_lambda();
  localparam logic [63:0] TO_STD = build_to_std(LAMBDA);
  localparam logic [63:0] TO_CMP = build_to_cmp(TO_STD);

  logic [7:0] pre_std, core_in, core_out, post_std;
  logic [3:0] hi, lo, delta, dinv;

  assign pre_std  = mode_dec ? affine_inv(din) : din;
  assign core_in  = lin_map(TO_CMP, pre_std);
  assign hi       = core_in[7:4];
  assign lo       = core_in[3:0];
  assign delta    = scalar_sq(LAMBDA, hi) ^ g4_mul(hi, lo) ^ g4_sq(lo);
  assign dinv     = g4_inv(delta);
  assign core_out = {g4_mul(hi, dinv), g4_mul(hi ^ lo, dinv)};
  assign post_std = lin_map(TO_STD, core_out);
  assign dout     = mode_dec ? post_std : affine_fwd(post_std);

endmodule

// File: rtl/aes_sbox_shared_chk.sv
module aes_sbox_shared_chk (
  input logic       mode_dec,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic [7:0] core_in,
  input logic [7:0] core_out
);

  always_comb begin
    p_fwd_zero_r3: assert final (!(!mode_dec && din == 8'h00) || dout == 8'h63)
      else $error("R3 forward zero");
    p_inv_zero_r3: assert final (!(mode_dec && din == 8'h63) || dout == 8'h00)
      else $error("R3 inverse zero");
    p_core_zero_r3: assert final (core_in != 8'h00 || core_out == 8'h00)
      else $error("R3 inverter zero");
    p_core_nonzero_r1: assert final (core_in == 8'h00 || core_out != 8'h00)
      else $error("R1 inverter nonzero");
    p_no_fixed_r6: assert final (dout != din)
      else $error("R6 fixed point");
  end

endmodule

bind aes_sbox_shared aes_sbox_shared_chk u_chk (
  .mode_dec(mode_dec),
  .din(din),
  .dout(dout),
  .core_in(core_in),
  .core_out(core_out)
);

// File: tb/tb_aes_sbox_shared.sv
module tb_aes_sbox_shared;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_dec = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  int compared = 0;
  int mismatched = 0;
  logic [7:0] fwd_tab [256];
  logic [7:0] inv_tab [256];

  always #5 clk = ~clk;

  aes_sbox_shared dut (.mode_dec(mode_dec), .din(din), .dout(dout));

  function automatic logic [7:0] m8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_fwd(input logic [7:0] v);
    logic [7:0] r, b;
    r = 8'h01;
    for (int i = 0; i < 254; i++) r = m8(r, v);
    b = (v == 8'h00) ? 8'h00 : r;
    for (int i = 0; i < 8; i++)
      r[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  task automatic apply(input logic m, input logic [7:0] v, output logic [7:0] r);
    @(negedge clk);
    mode_dec = m;
    din = v;
    #2;
    r = dout;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic t_known_vectors();
    logic [7:0] r;
    apply(1'b0, 8'h00, r); check("R3", r, 8'h63);
    apply(1'b1, 8'h63, r); check("R3", r, 8'h00);
    apply(1'b0, 8'h01, r); check("R1", r, 8'h7C);
    apply(1'b0, 8'hFF, r); check("R1", r, 8'h16);
    apply(1'b1, 8'h00, r); check("R2", r, 8'h52);
  endtask

  task automatic t_mode_switch();
    logic [7:0] r;
    apply(1'b0, 8'h53, r); check("R7", r, 8'hED);
    apply(1'b1, 8'h53, r); check("R7", r, 8'h50);
    apply(1'b0, 8'h53, r); check("R7", r, 8'hED);
  endtask

  task automatic t_sweep_fwd();
    logic [7:0] r;
    for (int x = 0; x < 256; x++) begin
      apply(1'b0, 8'(x), r);
      check("R1", r, fwd_tab[x]);
      compared++;
      if (r == 8'(x)) begin
        mismatched++;
        $display("FAIL R6: got %02h expected not %02h", r, 8'(x));
      end
    end
  endtask

  task automatic t_sweep_inv();
    logic [7:0] r;
    for (int x = 0; x < 256; x++) begin
      apply(1'b1, 8'(x), r);
      check("R2", r, inv_tab[x]);
      compared++;
      if (r == 8'(x)) begin
        mismatched++;
        $display("FAIL R6: got %02h expected not %02h", r, 8'(x));
      end
    end
  endtask

  task automatic t_round_trips();
    logic [7:0] a, b;
    for (int x = 0; x < 256; x++) begin
      apply(1'b0, 8'(x), a);
      apply(1'b1, a, b);
      check("R4", b, 8'(x));
      apply(1'b1, 8'(x), a);
      apply(1'b0, a, b);
      check("R5", b, 8'(x));
    end
  endtask

  initial begin
    for (int x = 0; x < 256; x++) fwd_tab[x] = ref_fwd(8'(x));
    for (int x = 0; x < 256; x++) inv_tab[fwd_tab[x]] = 8'(x);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_known_vectors();
    t_mode_switch();
    t_sweep_fwd();
    t_sweep_inv();
    t_round_trips();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule